// File: doc/BRIEF.md
# Byte-Lane DDR Sample Demultiplexer

This block sits behind the receivers of a 16-bit parallel sample port that carries two byte lanes. Each 16-bit sample arrives as two bytes: a high byte during one level of a data-phase indicator and a low byte during the other level. A frame level picks the channel pair that owns the current bytes. The upper lane feeds one channel and the lower lane feeds another, so four 16-bit sample streams come back from one port.

The phase indicator is sampled as a level in the block's clock. Each change of its level starts the next byte phase, and exactly one byte pair is captured per change. A configuration input inverts the sense of the phase indicator. A second configuration input bit-reverses every byte before assembly, for sources that send each byte LSB-first. A sample is published, with a one-cycle strobe on its channel, only when its high and low bytes were both captured under the same frame level.

Top module: `byte_demux`

## Requirements
- R1: The byte captured in the high phase (`dci_i ^ cfg_dci_inv_i` = 1) becomes bits 15:8 of a sample. The byte captured in the following low phase becomes bits 7:0.
- R2: With `frame_i` = 1, the upper lane `lane_data_i[15:8]` assembles into channel 0 (`ch_data_o[15:0]`) and the lower lane `lane_data_i[7:0]` into channel 2 (`ch_data_o[47:32]`).
- R3: With `frame_i` = 0, the upper lane assembles into channel 1 (`ch_data_o[31:16]`) and the lower lane into channel 3 (`ch_data_o[63:48]`).
- R4: A continuous alternation of frame-high pairs and frame-low pairs refreshes all four channels, with each channel keeping its own stream.
- R5: With `cfg_swap_i` = 0, the bus bit positions are used as they arrive, so the sample MSB is taken from bit 15 of the upper lane and bit 7 of the lower lane.
- R6: With `cfg_swap_i` = 1, each byte is bit-reversed before assembly, so the sample MSB is taken from bit 8 of the upper lane and bit 0 of the lower lane.
- R7: With `cfg_dci_inv_i` = 1, `dci_i` low is the high-byte phase and `dci_i` high is the low-byte phase.
- R8: A byte pair is captured only on a cycle where the internal phase differs from the previous cycle. A phase level that is held for extra cycles captures nothing further.
- R9: `ch_valid_o[k]` pulses high for exactly one cycle. The pulse appears right after the clock edge that captures the low byte, together with the new `ch_data_o` word. Between pulses a channel's word holds its value.
- R10: If `frame_i` differs between a high-byte capture and the matching low-byte capture, the pair is dropped. No strobe fires and no channel word changes.
- R11: Asynchronous reset (`rst_ni` = 0) clears all channel words, strobes and partial bytes. After reset, a low phase seen before any high phase produces nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_data_i | input | 16 | Two byte lanes: upper [15:8], lower [7:0] |
| dci_i | input | 1 | Sampled byte-phase indicator |
| frame_i | input | 1 | Channel-pair select (1: channels 0/2, 0: channels 1/3) |
| cfg_swap_i | input | 1 | Bit-reverse each received byte |
| cfg_dci_inv_i | input | 1 | Invert the sense of dci_i |
| ch_data_o | output | 64 | Four 16-bit channel words, channel k at [16k+15:16k] |
| ch_valid_o | output | 4 | One-cycle strobe per channel |

## Verification
The bench drives single frame-high and frame-low pairs with distinct byte values in all four lane/phase slots. A byte that lands in the wrong channel, the wrong half or the wrong lane therefore shows up as a wrong value. A longer continuous stream with changing data tells stale channel words apart from fresh ones. The same pairs are resent with bit reversal and with the phase sense inverted, using asymmetric byte values so that a missing or doubled reversal shows. A phase held for extra cycles, a frame flip inside a pair, and a reset that lands between the high and low bytes separate correct phase tracking and pair discard from logic that would capture too often or keep a stale partial byte.

// File: rtl/byte_demux_pkg.sv
package byte_demux_pkg;
  parameter int unsigned DEF_LANES  = 2;
  parameter int unsigned DEF_BYTE_W = 8;

  typedef enum logic {
    PH_LO = 1'b0,
    PH_HI = 1'b1
  } phase_e;
endpackage

// File: rtl/phase_tracker.sv
module phase_tracker
  import byte_demux_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dci_i,
  input  logic inv_i,
  output logic hi_stb_o,
  output logic lo_stb_o
);
  phase_e cur_phase;
  phase_e prev_q;

  assign cur_phase = phase_e'(dci_i ^ inv_i);

  // prev resets to low so the first high phase after reset is a change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= PH_LO;
    else         prev_q <= cur_phase;
  end

  assign hi_stb_o = (cur_phase == PH_HI) && (prev_q == PH_LO);
  assign lo_stb_o = (cur_phase == PH_LO) && (prev_q == PH_HI);

  // R8: a held phase never captures twice in a row
  a_r8_no_double_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_stb_o |=> !hi_stb_o);
  a_r8_no_double_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_stb_o |=> !lo_stb_o);
endmodule

// File: rtl/byte_reorder.sv
module byte_reorder #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned BUS_W = LANES * BYTE_W
) (
  input  logic             swap_i,
  input  logic [BUS_W-1:0] bus_i,
  output logic [BUS_W-1:0] bus_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
      assign bus_o[l*BYTE_W + b] = swap_i ? bus_i[l*BYTE_W + BYTE_W - 1 - b]
                                          : bus_i[l*BYTE_W + b];
    end
  end
endmodule

// File: rtl/pair_assembler.sv
module pair_assembler #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_stb_i,
  input  logic              lo_stb_i,
  input  logic              frame_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o,
  output logic              frame_o
);
  logic [BYTE_W-1:0] hi_q;
  logic              tag_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      tag_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (hi_stb_i) begin
      hi_q   <= byte_i;
      tag_q  <= frame_i;
      pend_q <= 1'b1;
    end else if (lo_stb_i) begin
      pend_q <= 1'b0;
    end
  end

  // pair completes only under the frame level seen at the high byte
  assign done_o  = lo_stb_i && pend_q && (tag_q == frame_i);
  assign word_o  = {hi_q, byte_i};
  assign frame_o = tag_q;

  // R11: a completed pair always had a high capture since reset
  a_r11_pend_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_stb_i |=> !pend_q);
endmodule

// File: rtl/lane_steer.sv
module lane_steer #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W,
  localparam int unsigned CH_N   = 2 * LANES
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [LANES-1:0]             done_i,
  input  logic [LANES-1:0]             frame_i,
  input  logic [LANES-1:0][WORD_W-1:0] word_i,
  output logic [CH_N-1:0][WORD_W-1:0]  ch_data_o,
  output logic [CH_N-1:0]              ch_valid_o
);
  // channel c: lane (top-down) c/2, frame high for even c
  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    localparam int unsigned LANE = LANES - 1 - c / 2;
    localparam logic        WANT = ((c % 2) == 0);
    logic hit;

    assign hit = done_i[LANE] && (frame_i[LANE] == WANT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ch_data_o[c]  <= '0;
        ch_valid_o[c] <= 1'b0;
      end else begin
        ch_valid_o[c] <= hit;
        if (hit) ch_data_o[c] <= word_i[LANE];
      end
    end

    // R9: strobe lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_valid_o[c] |=> !ch_valid_o[c]);
    // R9: word only moves together with its strobe
    a_r9_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_valid_o[c] |-> $stable(ch_data_o[c]));
  end
endmodule

// File: rtl/byte_demux.sv
module byte_demux
  import byte_demux_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned BYTE_W = DEF_BYTE_W,
  localparam int unsigned BUS_W  = LANES * BYTE_W,
  localparam int unsigned WORD_W = 2 * BYTE_W,
  localparam int unsigned CH_N   = 2 * LANES
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [BUS_W-1:0]         lane_data_i,
  input  logic                     dci_i,
  input  logic                     frame_i,
  input  logic                     cfg_swap_i,
  input  logic                     cfg_dci_inv_i,
  output logic [CH_N*WORD_W-1:0]   ch_data_o,
  output logic [CH_N-1:0]          ch_valid_o
);
  logic                         hi_stb, lo_stb;
  logic [BUS_W-1:0]             bus_ord;
  logic [LANES-1:0]             done;
  logic [LANES-1:0]             tag;
  logic [LANES-1:0][WORD_W-1:0] word;
  logic [CH_N-1:0][WORD_W-1:0]  ch_data;

  phase_tracker u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dci_i    (dci_i),
    .inv_i    (cfg_dci_inv_i),
    .hi_stb_o (hi_stb),
    .lo_stb_o (lo_stb)
  );

  byte_reorder #(.LANES(LANES), .BYTE_W(BYTE_W)) u_reorder (
    .swap_i (cfg_swap_i),
    .bus_i  (lane_data_i),
    .bus_o  (bus_ord)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_asm
    pair_assembler #(.BYTE_W(BYTE_W)) u_asm (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hi_stb_i (hi_stb),
      .lo_stb_i (lo_stb),
      .frame_i  (frame_i),
      .byte_i   (bus_ord[l*BYTE_W +: BYTE_W]),
      .word_o   (word[l]),
      .done_o   (done[l]),
      .frame_o  (tag[l])
    );
  end

  lane_steer #(.LANES(LANES), .BYTE_W(BYTE_W)) u_steer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .frame_i    (tag),
    .word_i     (word),
    .ch_data_o  (ch_data),
    .ch_valid_o (ch_valid_o)
  );

  assign ch_data_o = ch_data;

  // R2/R3: even channels only fire for a frame-high pair, odd for frame-low
  a_r2_frame_targets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_valid_o) |-> ($past(frame_i) == (ch_valid_o[0] | ch_valid_o[2])));
  // R10: strobes only follow a low-byte capture edge
  a_r10_valid_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_valid_o) |-> $past(lo_stb));
endmodule

// File: tb/byte_demux_tb.sv
module byte_demux_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] lane_data = '0;
  logic        dci = 1'b0;
  logic        frame = 1'b0;
  logic        swap = 1'b0;
  logic        inv = 1'b0;
  logic [63:0] ch_data;
  logic [3:0]  ch_valid;

  int n_vec = 0;
  int n_err = 0;
  logic [15:0] exp_w [4];

  always #2 clk = ~clk;

  byte_demux u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .lane_data_i   (lane_data),
    .dci_i         (dci),
    .frame_i       (frame),
    .cfg_swap_i    (swap),
    .cfg_dci_inv_i (inv),
    .ch_data_o     (ch_data),
    .ch_valid_o    (ch_valid)
  );

  function automatic logic [7:0] rev8(input logic [7:0] x);
    for (int i = 0; i < 8; i++) rev8[i] = x[7-i];
  endfunction

  function automatic logic [7:0] enc(input logic [7:0] x);
    return swap ? rev8(x) : x;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [3:0] exp_v);
    chk({req, " valid"}, {28'd0, ch_valid}, {28'd0, exp_v});
    for (int k = 0; k < 4; k++)
      chk($sformatf("%s ch%0d", req, k), {16'd0, ch_data[16*k +: 16]}, {16'd0, exp_w[k]});
  endtask

  task automatic step(input logic d, input logic f, input logic [15:0] bus);
    @(negedge clk);
    dci = d; frame = f; lane_data = bus;
    @(posedge clk);
    #1;
  endtask

  task automatic send_pair(input string req, input logic f,
                           input logic [7:0] u_hi, input logic [7:0] u_lo,
                           input logic [7:0] l_hi, input logic [7:0] l_lo);
    step(1'b1 ^ inv, f, {enc(u_hi), enc(l_hi)});
    check_out({req, " hi"}, 4'b0000);
    step(1'b0 ^ inv, f, {enc(u_lo), enc(l_lo)});
    if (f) begin exp_w[0] = {u_hi, u_lo}; exp_w[2] = {l_hi, l_lo}; end
    else   begin exp_w[1] = {u_hi, u_lo}; exp_w[3] = {l_hi, l_lo}; end
    check_out({req, " lo"}, f ? 4'b0101 : 4'b1010);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 4; k++) exp_w[k] = '0;
    #1;
    check_out("R11 reset", 4'b0000);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    check_out("R11 after release", 4'b0000);
  endtask

  task automatic t_basic;
    send_pair("R1 R2 R5 frame-high", 1'b1, 8'hA1, 8'h5B, 8'hC3, 8'h2D);
    send_pair("R1 R3 R5 frame-low",  1'b0, 8'h47, 8'h98, 8'hE6, 8'h1F);
    step(1'b0, 1'b0, 16'hFFFF);
    check_out("R9 pulse ends", 4'b0000);
  endtask

  task automatic t_stream;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] s;
      s = 8'(i * 37 + 11);
      send_pair("R4 stream", i[0] == 1'b0, s, s ^ 8'h5A, s + 8'h13, ~s);
    end
  endtask

  task automatic t_swap;
    swap = 1'b1;
    send_pair("R6 swap frame-high", 1'b1, 8'h81, 8'h06, 8'h3C, 8'hE0);
    send_pair("R6 swap frame-low",  1'b0, 8'h12, 8'hF4, 8'h70, 8'h0B);
    swap = 1'b0;
    send_pair("R5 swap off", 1'b1, 8'h81, 8'h06, 8'h3C, 8'hE0);
  endtask

  task automatic t_inv;
    // switch inversion together with dci so the internal phase stays low
    @(negedge clk); inv = 1'b1; dci = 1'b1;
    @(posedge clk); #1;
    check_out("R7 inv switch", 4'b0000);
    send_pair("R7 inverted frame-high", 1'b1, 8'h9E, 8'h61, 8'h04, 8'hB7);
    send_pair("R7 inverted frame-low",  1'b0, 8'h33, 8'hCC, 8'h55, 8'hAA);
    @(negedge clk); inv = 1'b0; dci = 1'b0;
    @(posedge clk); #1;
    check_out("R7 inv restore", 4'b0000);
  endtask

  task automatic t_hold;
    step(1'b1, 1'b1, 16'h6E_29);
    check_out("R8 first high", 4'b0000);
    step(1'b1, 1'b1, 16'hDD_DD);
    check_out("R8 held high", 4'b0000);
    step(1'b0, 1'b1, 16'h17_B0);
    exp_w[0] = 16'h6E17; exp_w[2] = 16'h29B0;
    check_out("R8 R9 low after hold", 4'b0101);
    step(1'b0, 1'b1, 16'h44_44);
    check_out("R8 R9 held low", 4'b0000);
  endtask

  task automatic t_mismatch;
    step(1'b1, 1'b1, 16'hF0_0F);
    check_out("R10 high frame1", 4'b0000);
    step(1'b0, 1'b0, 16'h12_34);
    check_out("R10 low frame0 dropped", 4'b0000);
    step(1'b1, 1'b0, 16'h0F_F0);
    step(1'b0, 1'b1, 16'h56_78);
    check_out("R10 low frame1 dropped", 4'b0000);
    send_pair("R10 recovery", 1'b0, 8'h21, 8'h43, 8'h65, 8'h87);
  endtask

  task automatic t_reset_mid;
    step(1'b1, 1'b1, 16'hBE_EF);
    @(negedge clk); rst_ni = 1'b0; dci = 1'b0;
    #1;
    for (int k = 0; k < 4; k++) exp_w[k] = '0;
    check_out("R11 mid reset", 4'b0000);
    @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    step(1'b0, 1'b1, 16'hCA_FE);
    check_out("R11 low first ignored", 4'b0000);
    send_pair("R11 resume", 1'b1, 8'h0D, 8'hF0, 8'h7E, 8'h81);
  endtask

  initial begin
    #(4 * 50000);
    n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    @(posedge clk);
    t_reset();
    t_basic();
    t_stream();
    t_swap();
    t_inv();
    t_hold();
    t_mismatch();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule